// File: doc/BRIEF.md
# Memory Access Control Timing Engine

This block runs one external memory access at a time on a fast functional clock. A one-cycle start pulse opens an access. From then on a cycle counter drives four active-low control strobes: chip select, address valid, output enable and write enable. Each strobe goes low and comes back high at its own programmed count. The engine also raises a single capture pulse at the programmed access time, one line for reads and one for writes. A done pulse marks the end of the access once the programmed cycle time is reached.

Reads and writes each have their own access-time count and their own cycle-time count. A shared granularity bit doubles both access times. In asynchronous mode the capture falls exactly on the access time. In synchronous mode the capture waits for the first functional cycle at or after the access time that is opened by a rising edge of the memory clock. That edge is reported on an input strobe. Any strobe can be moved later by half a functional clock period, which helps when the memory clock runs at the functional rate. At the start of each access the engine also latches a configuration-error flag. The flag is set when a deassertion, with its half-cycle delay, would not finish before the cycle time.

All counts are taken from the inputs and must stay stable while an access is in progress. The kind flags and the half-cycle selects are latched when the access starts.

Top module: `mte_timing_engine`

## Requirements
- R1: After reset, and in every cycle when no access is in progress, cs_n, adv_n, oe_n and we_n are high, and done, rd_cap and wr_cap are low. cfg_err is low after reset.
- R2: Number the functional cycles of an access t = 0, 1, 2, and so on, where t = 0 is the cycle right after the clock edge that samples start. Without half-cycle delay, cs_n and adv_n are low exactly in the cycles on <= t < off, using their own on and off counts.
- R3: oe_n follows the R2 window only on reads (is_write = 0), and we_n only on writes (is_write = 1). The unused one stays high for the whole access.
- R4: half_dly bit 0 selects chip select, bit 1 address valid, bit 2 output enable and bit 3 write enable. When a bit is set, both edges of that strobe move from the rising clock edge to the falling edge half a period later.
- R5: The cycle time is rd_cycle on reads and wr_cycle on writes. done is high for exactly the one cycle t = cycle time. In the cycle after that the engine is idle, and a start pulse there opens a new access.
- R6: A start pulse while an access is in progress is ignored, including in the done cycle. The current access keeps its timing, and no new access follows it.
- R7: The effective access time is rd_acc on reads and wr_acc on writes, multiplied by 2 when gran_x2 = 1 and by 1 otherwise. Exactly one capture pulse is produced per access: rd_cap on reads, wr_cap on writes.
- R8: In asynchronous mode (is_sync = 0) the capture pulse is high in cycle t equal to the effective access time. If that time is beyond the cycle time, there is no pulse.
- R9: In synchronous mode (is_sync = 1) the capture pulse is high in the first cycle t at or after the effective access time whose opening clock edge sampled mclk_rise high. If no such cycle exists up to the cycle time, there is no pulse.
- R10: cfg_err is updated only at the edge that starts an access and then holds. It is set when, counted in half cycles, 2*off + half_dly bit >= 2*cycle time for chip select, for address valid, for output enable on a read, or for write enable on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle access request |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| is_sync | input | 1 | 1 for synchronous capture alignment |
| half_dly | input | 4 | Per-strobe half-period delay enables (cs, adv, oe, we) |
| cs_on | input | CNT_W | Chip-select assertion count |
| cs_off | input | CNT_W | Chip-select deassertion count |
| adv_on | input | CNT_W | Address-valid assertion count |
| adv_off | input | CNT_W | Address-valid deassertion count |
| oe_on | input | CNT_W | Output-enable assertion count |
| oe_off | input | CNT_W | Output-enable deassertion count |
| we_on | input | CNT_W | Write-enable assertion count |
| we_off | input | CNT_W | Write-enable deassertion count |
| rd_acc | input | CNT_W | Read access-time count |
| wr_acc | input | CNT_W | Write access-time count |
| gran_x2 | input | 1 | Doubles both access times |
| rd_cycle | input | CNT_W | Read cycle time |
| wr_cycle | input | CNT_W | Write cycle time |
| mclk_rise | input | 1 | Memory clock rising-edge strobe |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| rd_cap | output | 1 | Read data-capture pulse |
| wr_cap | output | 1 | Write data-capture pulse |
| done | output | 1 | One-cycle end-of-access pulse |
| cfg_err | output | 1 | Configuration error for the current access |

## Verification
Every strobe is sampled twice per cycle, shortly after the rising edge and again after the falling edge. A delay select that is ignored, or that moves only one edge, then shows up as a wrong level at one of the two points. Two boundary cases are aimed at directly: an access time equal to the cycle time, which a design that stops one cycle early would miss, and an access time past the cycle time, which a design that does not mask the capture outside the access would still pulse on. Start pulses in the middle of an access and in its done cycle check that the counter is never restarted and that no second access slips in. Error-flag cases check that a deassertion at the cycle time is flagged, and that an unused output or write enable with an out-of-range count is not.

// File: rtl/mte_pkg.sv
package mte_pkg;

  localparam int NUM_SIG = 4;

  // Strobe slot order; half_dly bit positions follow it.
  typedef enum logic [1:0] {
    SIG_CS  = 2'd0,
    SIG_ADV = 2'd1,
    SIG_OE  = 2'd2,
    SIG_WE  = 2'd3
  } sig_e;

  // Effective access time in functional cycles.
  function automatic int unsigned eff_time(int unsigned cnt, logic x2);
    return x2 ? cnt * 2 : cnt;
  endfunction

  // Strobe active window for cycle index t.
  function automatic logic in_window(int unsigned t, int unsigned on_t,
                                     int unsigned off_t);
    return (t >= on_t) && (t < off_t);
  endfunction

  // Deassertion (in half cycles) reaching the cycle time.
  function automatic logic past_end(int unsigned off_t, logic half,
                                    int unsigned cyc);
    return (off_t * 2 + 32'(half)) >= cyc * 2;
  endfunction

endpackage

// File: rtl/mte_seq.sv
module mte_seq #(
  parameter int CNT_W = 5,
  parameter int T_W   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             is_sync,
  input  logic [CNT_W-1:0] rd_cycle,
  input  logic [CNT_W-1:0] wr_cycle,
  output logic             accept,
  output logic             busy_q,
  output logic             busy_nxt,
  output logic [T_W-1:0]   t_q,
  output logic [T_W-1:0]   t_nxt,
  output logic             wr_q,
  output logic             wr_nxt,
  output logic             sync_q,
  output logic             sync_nxt,
  output logic             done
);

  logic [CNT_W-1:0] cyc_now;
  logic [CNT_W-1:0] cyc_next;
  logic             end_now;
  logic             done_nxt;

  always_comb begin
    accept   = start && !busy_q;
    wr_nxt   = accept ? is_write : wr_q;
    sync_nxt = accept ? is_sync  : sync_q;
    cyc_now  = wr_q ? wr_cycle : rd_cycle;
    end_now  = busy_q && (t_q == T_W'(cyc_now));
    busy_nxt = accept || (busy_q && !end_now);
    if (accept)        t_nxt = '0;
    else if (busy_nxt) t_nxt = t_q + T_W'(1);
    else               t_nxt = '0;
    cyc_next = wr_nxt ? wr_cycle : rd_cycle;
    done_nxt = busy_nxt && (t_nxt == T_W'(cyc_next));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      wr_q   <= 1'b0;
      sync_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      busy_q <= busy_nxt;
      t_q    <= t_nxt;
      wr_q   <= wr_nxt;
      sync_q <= sync_nxt;
      done   <= done_nxt;
    end
  end

  // R5: done lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: after the done cycle the engine is idle even if start was high
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R6: mid-access the counter only advances
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !end_now) |=> (busy_q && (t_q == $past(t_q) + T_W'(1))));

endmodule

// File: rtl/mte_strobe.sv
module mte_strobe #(
  parameter int CNT_W = 5,
  parameter int T_W   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             busy_q,
  input  logic             busy_nxt,
  input  logic             used_nxt,
  input  logic [T_W-1:0]   t_nxt,
  input  logic [CNT_W-1:0] on_t,
  input  logic [CNT_W-1:0] off_t,
  input  logic             dly_in,
  output logic             strb_n
);
  import mte_pkg::*;

  logic win;
  logic pos_act;
  logic neg_act;
  logic sel_q;

  always_comb begin
    win = busy_nxt && used_nxt &&
          in_window(32'(t_nxt), 32'(on_t), 32'(off_t));
  end

  // Select changes only at an access start, when both paths are idle or
  // move together, so the output mux cannot glitch mid-access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_act <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      pos_act <= win;
      if (accept) sel_q <= dly_in;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_act <= 1'b0;
    else        neg_act <= pos_act;
  end

  assign strb_n = ~(sel_q ? neg_act : pos_act);

  // R4: the falling-edge copy has caught up by the next rising edge
  a_r4_half_follow: assert property (@(posedge clk) disable iff (!rst_n)
    neg_act == pos_act);

  // R4: the delay select is frozen for the whole access
  a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(sel_q));

endmodule

// File: rtl/mte_capture.sv
module mte_capture #(
  parameter int CNT_W = 5,
  parameter int T_W   = CNT_W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           busy_nxt,
  input  logic [T_W-1:0] t_nxt,
  input  logic           wr_nxt,
  input  logic           sync_nxt,
  input  logic [T_W-1:0] eff_t,
  input  logic           mclk_rise,
  output logic           rd_cap,
  output logic           wr_cap
);

  logic taken_q;
  logic taken_now;
  logic reached;
  logic edge_ok;
  logic hit;
  logic sync_q;

  always_comb begin
    taken_now = accept ? 1'b0 : taken_q;
    reached   = t_nxt >= eff_t;
    edge_ok   = sync_nxt ? mclk_rise : (t_nxt == eff_t);
    hit       = busy_nxt && !taken_now && reached && edge_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      rd_cap  <= 1'b0;
      wr_cap  <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      taken_q <= taken_now || hit;
      rd_cap  <= hit && !wr_nxt;
      wr_cap  <= hit && wr_nxt;
      sync_q  <= sync_nxt;
    end
  end

  // R9: synchronous capture only on a cycle opened by a memory clock rise
  a_r9_sync_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_cap || wr_cap) && sync_q) |-> $past(mclk_rise));

  // R7: a single capture pulse, never on both lines
  a_r7_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cap || wr_cap) |=> !(rd_cap || wr_cap));

  a_r7_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cap && wr_cap));

endmodule

// File: rtl/mte_cfg_check.sv
module mte_cfg_check #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             is_write,
  input  logic [CNT_W-1:0] off_cs,
  input  logic [CNT_W-1:0] off_adv,
  input  logic [CNT_W-1:0] off_oe,
  input  logic [CNT_W-1:0] off_we,
  input  logic [3:0]       half,
  input  logic [CNT_W-1:0] rd_cycle,
  input  logic [CNT_W-1:0] wr_cycle,
  output logic             cfg_err
);
  import mte_pkg::*;

  logic [CNT_W-1:0] cyc;
  logic             bad;

  always_comb begin
    cyc = is_write ? wr_cycle : rd_cycle;
    bad = past_end(32'(off_cs),  half[SIG_CS],  32'(cyc)) ||
          past_end(32'(off_adv), half[SIG_ADV], 32'(cyc)) ||
          (!is_write && past_end(32'(off_oe), half[SIG_OE], 32'(cyc))) ||
          ( is_write && past_end(32'(off_we), half[SIG_WE], 32'(cyc)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_err <= 1'b0;
    else if (accept) cfg_err <= bad;
  end

  // R10: the flag only moves at an access start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(cfg_err));

endmodule

// File: rtl/mte_timing_engine.sv
module mte_timing_engine #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             is_sync,
  input  logic [3:0]       half_dly,
  input  logic [CNT_W-1:0] cs_on,
  input  logic [CNT_W-1:0] cs_off,
  input  logic [CNT_W-1:0] adv_on,
  input  logic [CNT_W-1:0] adv_off,
  input  logic [CNT_W-1:0] oe_on,
  input  logic [CNT_W-1:0] oe_off,
  input  logic [CNT_W-1:0] we_on,
  input  logic [CNT_W-1:0] we_off,
  input  logic [CNT_W-1:0] rd_acc,
  input  logic [CNT_W-1:0] wr_acc,
  input  logic             gran_x2,
  input  logic [CNT_W-1:0] rd_cycle,
  input  logic [CNT_W-1:0] wr_cycle,
  input  logic             mclk_rise,
  output logic             cs_n,
  output logic             adv_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             rd_cap,
  output logic             wr_cap,
  output logic             done,
  output logic             cfg_err
);
  import mte_pkg::*;

  localparam int T_W = CNT_W + 1;

  logic           accept;
  logic           busy_q;
  logic           busy_nxt;
  logic [T_W-1:0] t_q;
  logic [T_W-1:0] t_nxt;
  logic           wr_q;
  logic           wr_nxt;
  logic           sync_q;
  logic           sync_nxt;
  logic [T_W-1:0] rd_eff;
  logic [T_W-1:0] wr_eff;
  logic [T_W-1:0] cap_eff;

  logic [NUM_SIG-1:0][CNT_W-1:0] on_a;
  logic [NUM_SIG-1:0][CNT_W-1:0] off_a;
  logic [NUM_SIG-1:0]            strb_n_a;

  always_comb begin
    rd_eff  = T_W'(eff_time(32'(rd_acc), gran_x2));
    wr_eff  = T_W'(eff_time(32'(wr_acc), gran_x2));
    cap_eff = wr_nxt ? wr_eff : rd_eff;
    on_a    = {we_on,  oe_on,  adv_on,  cs_on};
    off_a   = {we_off, oe_off, adv_off, cs_off};
  end

  mte_seq #(.CNT_W(CNT_W), .T_W(T_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_write (is_write),
    .is_sync  (is_sync),
    .rd_cycle (rd_cycle),
    .wr_cycle (wr_cycle),
    .accept   (accept),
    .busy_q   (busy_q),
    .busy_nxt (busy_nxt),
    .t_q      (t_q),
    .t_nxt    (t_nxt),
    .wr_q     (wr_q),
    .wr_nxt   (wr_nxt),
    .sync_q   (sync_q),
    .sync_nxt (sync_nxt),
    .done     (done)
  );

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_strb
    logic used;
    if (g == int'(SIG_OE)) begin : g_oe
      assign used = !wr_nxt;
    end else if (g == int'(SIG_WE)) begin : g_we
      assign used = wr_nxt;
    end else begin : g_all
      assign used = 1'b1;
    end

    mte_strobe #(.CNT_W(CNT_W), .T_W(T_W)) u_strb (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .busy_q   (busy_q),
      .busy_nxt (busy_nxt),
      .used_nxt (used),
      .t_nxt    (t_nxt),
      .on_t     (on_a[g]),
      .off_t    (off_a[g]),
      .dly_in   (half_dly[g]),
      .strb_n   (strb_n_a[g])
    );
  end

  assign cs_n  = strb_n_a[SIG_CS];
  assign adv_n = strb_n_a[SIG_ADV];
  assign oe_n  = strb_n_a[SIG_OE];
  assign we_n  = strb_n_a[SIG_WE];

  mte_capture #(.CNT_W(CNT_W), .T_W(T_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .busy_nxt  (busy_nxt),
    .t_nxt     (t_nxt),
    .wr_nxt    (wr_nxt),
    .sync_nxt  (sync_nxt),
    .eff_t     (cap_eff),
    .mclk_rise (mclk_rise),
    .rd_cap    (rd_cap),
    .wr_cap    (wr_cap)
  );

  mte_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .is_write (is_write),
    .off_cs   (cs_off),
    .off_adv  (adv_off),
    .off_oe   (oe_off),
    .off_we   (we_off),
    .half     (half_dly),
    .rd_cycle (rd_cycle),
    .wr_cycle (wr_cycle),
    .cfg_err  (cfg_err)
  );

  // R1: outside an access every strobe is high and no pulse is seen
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cs_n && adv_n && oe_n && we_n && !done && !rd_cap && !wr_cap));

  // R3: output enable never moves on a write, write enable never on a read
  a_r3_oe_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q) |-> oe_n);

  a_r3_we_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_q) |-> we_n);

  // R8: asynchronous capture sits exactly on the effective access time
  a_r8_async_time: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_cap || wr_cap) && !sync_q) |-> (t_q == (wr_q ? wr_eff : rd_eff)));

endmodule

// File: tb/tb_mte_timing_engine.sv
module tb_mte_timing_engine;

  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_write = 1'b0, is_sync = 1'b0;
  logic gran_x2 = 1'b0, mclk_rise = 1'b0;
  logic [3:0] half_dly = '0;
  logic [CW-1:0] cs_on = '0, cs_off = '0, adv_on = '0, adv_off = '0;
  logic [CW-1:0] oe_on = '0, oe_off = '0, we_on = '0, we_off = '0;
  logic [CW-1:0] rd_acc = '0, wr_acc = '0, rd_cycle = '0, wr_cycle = '0;
  logic cs_n, adv_n, oe_n, we_n, rd_cap, wr_cap, done, cfg_err;

  always #5 clk = ~clk;

  mte_timing_engine #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .is_sync(is_sync), .half_dly(half_dly),
    .cs_on(cs_on), .cs_off(cs_off), .adv_on(adv_on), .adv_off(adv_off),
    .oe_on(oe_on), .oe_off(oe_off), .we_on(we_on), .we_off(we_off),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .gran_x2(gran_x2),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .mclk_rise(mclk_rise),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .rd_cap(rd_cap), .wr_cap(wr_cap), .done(done), .cfg_err(cfg_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int c_on[4], c_off[4];
  bit c_x[4];
  int rdacc, wracc, rcyc, wcyc;
  bit c_wr, c_sy, c_g;
  bit mr[64];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit live(int k, int lo, int hi);
    return !(k < lo) && (hi > k);
  endfunction

  function automatic bit slot_used(int i);
    if (i == 2) return !c_wr;
    if (i == 3) return c_wr;
    return 1'b1;
  endfunction

  function automatic int strobe_val(int i);
    case (i)
      0: return int'(cs_n);
      1: return int'(adv_n);
      2: return int'(oe_n);
      default: return int'(we_n);
    endcase
  endfunction

  function automatic string slot_tag(int i, int k, int cyc);
    if (k == cyc + 1) return "R1 idle strobe";
    if (c_x[i]) return "R4 delayed strobe";
    if (i < 2) return "R2 cs/adv strobe";
    return "R3 oe/we strobe";
  endfunction

  task automatic set_mr(input int d, input int ph);
    for (int k = 0; k < 64; k++) mr[k] = (((k + ph) % d) == 0);
  endtask

  task automatic apply_cfg();
    is_write = c_wr; is_sync = c_sy; gran_x2 = c_g;
    half_dly = {c_x[3], c_x[2], c_x[1], c_x[0]};
    cs_on  = CW'(c_on[0]); cs_off  = CW'(c_off[0]);
    adv_on = CW'(c_on[1]); adv_off = CW'(c_off[1]);
    oe_on  = CW'(c_on[2]); oe_off  = CW'(c_off[2]);
    we_on  = CW'(c_on[3]); we_off  = CW'(c_off[3]);
    rd_acc = CW'(rdacc); wr_acc = CW'(wracc);
    rd_cycle = CW'(rcyc); wr_cycle = CW'(wcyc);
  endtask

  // One access; ign_k >= 0 pulses start during that busy cycle (R6).
  task automatic run_access(input int ign_k);
    int cyc, acc, cap_k;
    bit err;
    cyc = c_wr ? wcyc : rcyc;
    acc = (c_wr ? wracc : rdacc) * (c_g ? 2 : 1);
    cap_k = -1;
    if (c_sy) begin
      for (int k = acc; k <= cyc; k++) if (mr[k] && cap_k < 0) cap_k = k;
    end else if (acc <= cyc) cap_k = acc;
    err = 0;
    for (int i = 0; i < 4; i++) if (slot_used(i) && c_off[i] >= cyc) err = 1;

    @(negedge clk);
    apply_cfg();
    start = 1'b1;
    mclk_rise = mr[0];
    @(posedge clk);
    #2;
    for (int k = 0; k <= cyc + 1; k++) begin
      start = (k == ign_k);
      if (k == 0) chk("R10 cfg_err", int'(cfg_err), int'(err));
      chk(ign_k >= 0 ? "R6 done with ignored start" : "R5 done",
          int'(done), int'(k == cyc));
      chk(c_sy ? "R7/R9 rd_cap" : "R7/R8 rd_cap", int'(rd_cap),
          int'((k == cap_k) && !c_wr));
      chk(c_sy ? "R7/R9 wr_cap" : "R7/R8 wr_cap", int'(wr_cap),
          int'((k == cap_k) && c_wr));
      if (!err) begin
        for (int i = 0; i < 4; i++) begin
          bit low;
          if (c_x[i]) low = slot_used(i) && (k >= 1) && live(k - 1, c_on[i], c_off[i]);
          else        low = slot_used(i) && (k <= cyc) && live(k, c_on[i], c_off[i]);
          chk(slot_tag(i, k, cyc), strobe_val(i), int'(!low));
        end
      end
      #5;
      mclk_rise = (k + 1 < 64) ? mr[k + 1] : 1'b0;
      if (!err) begin
        for (int i = 0; i < 4; i++) begin
          bit low;
          low = slot_used(i) && (k <= cyc) && live(k, c_on[i], c_off[i]);
          chk(slot_tag(i, k, cyc), strobe_val(i), int'(!low));
        end
      end
      #5;
    end
    start = 1'b0;
    mclk_rise = 1'b0;
  endtask

  task automatic rand_cfg();
    int cyc;
    c_wr = 1'($urandom_range(0, 1));
    c_sy = 1'($urandom_range(0, 1));
    c_g  = 1'($urandom_range(0, 1));
    rcyc = $urandom_range(2, 31);
    wcyc = $urandom_range(2, 31);
    cyc = c_wr ? wcyc : rcyc;
    for (int i = 0; i < 4; i++) begin
      c_off[i] = $urandom_range(0, cyc - 1);
      c_on[i]  = $urandom_range(0, c_off[i]);
      c_x[i]   = 1'($urandom_range(0, 1));
    end
    rdacc = $urandom_range(0, 15);
    wracc = $urandom_range(0, 15);
    set_mr($urandom_range(1, 4), $urandom_range(0, 3));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 reset cs_n", int'(cs_n), 1);
    chk("R1 reset adv_n", int'(adv_n), 1);
    chk("R1 reset oe_n", int'(oe_n), 1);
    chk("R1 reset we_n", int'(we_n), 1);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset caps", int'(rd_cap || wr_cap), 0);
    chk("R1 reset cfg_err", int'(cfg_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Directed: async read, no delays (R2, R3, R8)
    c_wr = 0; c_sy = 0; c_g = 0; rcyc = 8; wcyc = 9;
    c_on = '{0, 1, 2, 0}; c_off = '{5, 3, 6, 0}; c_x = '{0, 0, 0, 0};
    rdacc = 4; wracc = 2; set_mr(1, 0);
    run_access(-1);
    // R7: doubled access time lands on the cycle time itself
    c_g = 1;
    run_access(-1);

    // Directed: sync write, all strobes delayed, start while busy (R4, R6, R9)
    c_wr = 1; c_sy = 1; c_g = 0; wcyc = 12;
    c_on = '{0, 0, 1, 3}; c_off = '{11, 2, 2, 9}; c_x = '{1, 1, 1, 1};
    wracc = 4; set_mr(2, 1);
    run_access(4);
    run_access(12);

    // R8: access time beyond cycle time, no pulse
    c_wr = 0; c_sy = 0; c_g = 0; rcyc = 10; rdacc = 20;
    c_on = '{0, 0, 1, 0}; c_off = '{9, 4, 8, 3}; c_x = '{0, 1, 0, 0};
    run_access(-1);
    // R9: no memory clock rise after the access time
    c_sy = 1; rdacc = 6;
    for (int k = 0; k < 64; k++) mr[k] = (k < 6) ? 1'b1 : 1'b0;
    run_access(-1);

    // R10: deassertion at the cycle time is flagged
    c_sy = 0; rdacc = 3; set_mr(1, 0);
    c_off = '{10, 4, 8, 3}; c_x = '{0, 0, 0, 0};
    run_access(-1);
    // R10: last half cycle still fits, unused write enable ignored
    c_off = '{9, 4, 9, 20}; c_x = '{1, 0, 1, 1};
    run_access(-1);

    // Constrained random accesses
    for (int n = 0; n < 60; n++) begin
      rand_cfg();
      run_access(($urandom_range(0, 3) == 0) ? 1 : -1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule